// File: doc/BRIEF.md
# Paced Interrupt Combiner

This block collects the interrupt requests of an eight-channel Ethernet controller and of its management interface. It folds them into four interrupt pulses for the CPU: receive, transmit, receive-threshold and miscellaneous. Each request line is a level. An enable bit per source masks it. A pulse is issued when any enabled source of a group newly becomes active.

Software can read the masked level of every group through status words. The receive and transmit pulses can be paced so that no more than a programmed number of them leave in one millisecond window. A prescaler divides the peripheral clock into a tick, and a fixed count of ticks forms a window. Requests that arrive after the budget is spent are held. They are merged into a single pulse when the next window opens.

Registers are reached through a simple word-addressed write strobe with a combinational read path. Addresses are word indices on `reg_addr_i`: 0 control, 1 threshold enable, 2 receive enable, 3 transmit enable, 4 miscellaneous enable, 5 threshold status, 6 receive status, 7 transmit status, 8 miscellaneous status, 9 receive budget, 10 transmit budget.

Top module: `irq_pace_top`

## Requirements
- R1: After reset every pulse output is low and every register word (0 to 10) reads zero.
- R2: With receive pacing off, a 0-to-1 change of any bit of the masked receive vector (`rx_req_i` AND word 2 bits 7:0) gives a one-cycle high on `rx_pulse_o` in the next cycle. A masked level that stays high gives no further pulse.
- R3: With transmit pacing off, the transmit group behaves as in R2, using `tx_req_i` and word 3 bits 7:0.
- R4: The threshold group (`th_req_i`, word 1 bits 7:0) behaves as in R2 and is never paced, whatever the pacing bits hold.
- R5: `misc_pulse_o` merges four sources, enabled by word 4 bits 3:0: bit 0 statistics, bit 1 host error, bit 2 link change, bit 3 user access done. Each enabled source alone produces a pulse.
- R6: A source whose enable bit is 0 produces no pulse and shows 0 in its status bit.
- R7: Words 5, 6, 7 and 8 read the masked levels of the threshold, receive, transmit and miscellaneous groups in their low bits. Writes to these words have no effect.
- R8: Word 0 holds the prescale value P in bits 11:0, receive pacing enable in bit 16 and transmit pacing enable in bit 17. One tick lasts P+1 clocks, and a window lasts 250 ticks.
- R9: With pacing on, a group issues at most its budget of pulses per window. The receive budget is word 9 bits 5:0 and the transmit budget is word 10 bits 5:0. A budget of 0 holds every request. Pacing of one group does not affect the other.
- R10: Requests held for lack of budget leave as exactly one pulse. It appears in the cycle after the first cycle of the next window.
- R11: Turning pacing off discards held requests, and later edges pulse at once as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| rx_req_i | input | 8 | Receive completion requests, one per channel |
| tx_req_i | input | 8 | Transmit completion requests, one per channel |
| th_req_i | input | 8 | Receive threshold requests, one per channel |
| misc_req_i | input | 4 | Statistics, host error, link change, user access done |
| rx_pulse_o | output | 1 | Receive interrupt pulse |
| tx_pulse_o | output | 1 | Transmit interrupt pulse |
| th_pulse_o | output | 1 | Receive-threshold interrupt pulse |
| misc_pulse_o | output | 1 | Miscellaneous interrupt pulse |

## Verification
The properties assume that request lines are levels synchronous to `clk_i` and that software writes one register word per strobe. The budget property also assumes the budget and the pacing bit stay unchanged inside the window it judges, and it stops judging as soon as either one moves. The stimulus changes requests only between clock edges and issues register writes one at a time. It changes the budget or the pacing bits only where a window's count is deliberately restarted.

// File: rtl/irq_pace_pkg.sv
package irq_pace_pkg;
  localparam int REG_AW    = 4;
  localparam int DATA_W    = 32;
  localparam int CH_N      = 8;
  localparam int MISC_W    = 4;
  localparam int MAX_W     = 6;
  localparam int PRE_W     = 12;
  localparam int WIN_TICKS = 250;
  localparam int PACE_RX_BIT = 16;
  localparam int PACE_TX_BIT = 17;

  localparam logic [REG_AW-1:0] A_CTRL      = 4'd0;
  localparam logic [REG_AW-1:0] A_TH_EN     = 4'd1;
  localparam logic [REG_AW-1:0] A_RX_EN     = 4'd2;
  localparam logic [REG_AW-1:0] A_TX_EN     = 4'd3;
  localparam logic [REG_AW-1:0] A_MISC_EN   = 4'd4;
  localparam logic [REG_AW-1:0] A_TH_STAT   = 4'd5;
  localparam logic [REG_AW-1:0] A_RX_STAT   = 4'd6;
  localparam logic [REG_AW-1:0] A_TX_STAT   = 4'd7;
  localparam logic [REG_AW-1:0] A_MISC_STAT = 4'd8;
  localparam logic [REG_AW-1:0] A_RX_MAX    = 4'd9;
  localparam logic [REG_AW-1:0] A_TX_MAX    = 4'd10;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int PRE_W     = 12,
  parameter int WIN_TICKS = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             win_start_o
);
  localparam int WIN_W = $clog2(WIN_TICKS);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_TICKS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [WIN_W-1:0] win_q;
  logic             tick;

  assign tick        = (pre_q >= prescale_i);
  assign win_start_o = tick && (win_q == WIN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      win_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) win_q <= (win_q == WIN_LAST) ? '0 : win_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_lane.sv
module irq_lane #(
  parameter int N     = 8,
  parameter bit PACED = 1'b0,
  parameter int MAX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     en_i,
  input  logic             pace_en_i,
  input  logic [MAX_W-1:0] max_i,
  input  logic             win_start_i,
  output logic [N-1:0]     stat_o,
  output logic             pulse_o
);
  logic [N-1:0] masked, prev_q;
  logic         edge_hit, fire;

  assign masked   = req_i & en_i;
  assign stat_o   = masked;
  assign edge_hit = |(masked & ~prev_q);

  generate
    if (PACED) begin : g_paced
      logic             pend_q, want;
      logic [MAX_W-1:0] cnt_q, cnt_base;

      always_comb begin
        cnt_base = win_start_i ? '0 : cnt_q;
        want     = edge_hit | pend_q;
        fire     = pace_en_i ? (want && (cnt_base < max_i)) : edge_hit;
      end

      // budget restarts whenever pacing is off
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          pend_q <= pace_en_i && want && !fire;
          cnt_q  <= pace_en_i ? cnt_base + MAX_W'(fire) : '0;
        end
      end
    end else begin : g_plain
      logic unused_pace;
      assign unused_pace = ^{pace_en_i, max_i, win_start_i};
      assign fire = edge_hit;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      pulse_o <= 1'b0;
    end else begin
      prev_q  <= masked;
      pulse_o <= fire;
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pace_pkg::*;
#(
  parameter int AW     = REG_AW,
  parameter int DW     = DATA_W,
  parameter int CH     = CH_N,
  parameter int MW     = MISC_W,
  parameter int MAXW   = MAX_W,
  parameter int PREW   = PRE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [CH-1:0]   th_stat_i,
  input  logic [CH-1:0]   rx_stat_i,
  input  logic [CH-1:0]   tx_stat_i,
  input  logic [MW-1:0]   misc_stat_i,
  output logic [PREW-1:0] prescale_o,
  output logic            pace_rx_o,
  output logic            pace_tx_o,
  output logic [CH-1:0]   th_en_o,
  output logic [CH-1:0]   rx_en_o,
  output logic [CH-1:0]   tx_en_o,
  output logic [MW-1:0]   misc_en_o,
  output logic [MAXW-1:0] rx_max_o,
  output logic [MAXW-1:0] tx_max_o
);
  logic unused_wbits;
  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prescale_o <= '0;
      pace_rx_o  <= 1'b0;
      pace_tx_o  <= 1'b0;
      th_en_o    <= '0;
      rx_en_o    <= '0;
      tx_en_o    <= '0;
      misc_en_o  <= '0;
      rx_max_o   <= '0;
      tx_max_o   <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_CTRL: begin
          prescale_o <= wdata_i[PREW-1:0];
          pace_rx_o  <= wdata_i[PACE_RX_BIT];
          pace_tx_o  <= wdata_i[PACE_TX_BIT];
        end
        A_TH_EN:   th_en_o   <= wdata_i[CH-1:0];
        A_RX_EN:   rx_en_o   <= wdata_i[CH-1:0];
        A_TX_EN:   tx_en_o   <= wdata_i[CH-1:0];
        A_MISC_EN: misc_en_o <= wdata_i[MW-1:0];
        A_RX_MAX:  rx_max_o  <= wdata_i[MAXW-1:0];
        A_TX_MAX:  tx_max_o  <= wdata_i[MAXW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[PREW-1:0]    = prescale_o;
        rdata_o[PACE_RX_BIT] = pace_rx_o;
        rdata_o[PACE_TX_BIT] = pace_tx_o;
      end
      A_TH_EN:     rdata_o[CH-1:0]   = th_en_o;
      A_RX_EN:     rdata_o[CH-1:0]   = rx_en_o;
      A_TX_EN:     rdata_o[CH-1:0]   = tx_en_o;
      A_MISC_EN:   rdata_o[MW-1:0]   = misc_en_o;
      A_TH_STAT:   rdata_o[CH-1:0]   = th_stat_i;
      A_RX_STAT:   rdata_o[CH-1:0]   = rx_stat_i;
      A_TX_STAT:   rdata_o[CH-1:0]   = tx_stat_i;
      A_MISC_STAT: rdata_o[MW-1:0]   = misc_stat_i;
      A_RX_MAX:    rdata_o[MAXW-1:0] = rx_max_o;
      A_TX_MAX:    rdata_o[MAXW-1:0] = tx_max_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_pace_top.sv
module irq_pace_top
  import irq_pace_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [CH_N-1:0]   rx_req_i,
  input  logic [CH_N-1:0]   tx_req_i,
  input  logic [CH_N-1:0]   th_req_i,
  input  logic [MISC_W-1:0] misc_req_i,
  output logic              rx_pulse_o,
  output logic              tx_pulse_o,
  output logic              th_pulse_o,
  output logic              misc_pulse_o
);
  logic [PRE_W-1:0]  prescale;
  logic              pace_rx, pace_tx, win_start;
  logic [CH_N-1:0]   th_en, rx_en, tx_en, th_stat, rx_stat, tx_stat;
  logic [MISC_W-1:0] misc_en, misc_stat;
  logic [MAX_W-1:0]  rx_max, tx_max;

  irq_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .th_stat_i(th_stat), .rx_stat_i(rx_stat), .tx_stat_i(tx_stat), .misc_stat_i(misc_stat),
    .prescale_o(prescale), .pace_rx_o(pace_rx), .pace_tx_o(pace_tx),
    .th_en_o(th_en), .rx_en_o(rx_en), .tx_en_o(tx_en), .misc_en_o(misc_en),
    .rx_max_o(rx_max), .tx_max_o(tx_max)
  );

  irq_tick_gen #(.PRE_W(PRE_W), .WIN_TICKS(WIN_TICKS)) u_tick (
    .clk_i, .rst_ni, .prescale_i(prescale), .win_start_o(win_start)
  );

  irq_lane #(.N(CH_N), .PACED(1'b1), .MAX_W(MAX_W)) u_rx (
    .clk_i, .rst_ni, .req_i(rx_req_i), .en_i(rx_en), .pace_en_i(pace_rx),
    .max_i(rx_max), .win_start_i(win_start), .stat_o(rx_stat), .pulse_o(rx_pulse_o)
  );

  irq_lane #(.N(CH_N), .PACED(1'b1), .MAX_W(MAX_W)) u_tx (
    .clk_i, .rst_ni, .req_i(tx_req_i), .en_i(tx_en), .pace_en_i(pace_tx),
    .max_i(tx_max), .win_start_i(win_start), .stat_o(tx_stat), .pulse_o(tx_pulse_o)
  );

  irq_lane #(.N(CH_N), .PACED(1'b0), .MAX_W(MAX_W)) u_th (
    .clk_i, .rst_ni, .req_i(th_req_i), .en_i(th_en), .pace_en_i(1'b0),
    .max_i('0), .win_start_i(win_start), .stat_o(th_stat), .pulse_o(th_pulse_o)
  );

  irq_lane #(.N(MISC_W), .PACED(1'b0), .MAX_W(MAX_W)) u_misc (
    .clk_i, .rst_ni, .req_i(misc_req_i), .en_i(misc_en), .pace_en_i(1'b0),
    .max_i('0), .win_start_i(win_start), .stat_o(misc_stat), .pulse_o(misc_pulse_o)
  );
endmodule

// File: rtl/irq_pace_chk.sv
module irq_pace_chk #(
  parameter int CH    = 8,
  parameter int MW    = 4,
  parameter int MAXW  = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rx_pulse_i,
  input logic            th_pulse_i,
  input logic            misc_pulse_i,
  input logic [CH-1:0]   rx_stat_i,
  input logic [CH-1:0]   th_stat_i,
  input logic [MW-1:0]   misc_stat_i,
  input logic [CH-1:0]   rx_en_i,
  input logic            pace_rx_i,
  input logic [MAXW-1:0] rx_max_i,
  input logic            win_start_i
);
  logic            win_d, pace_d, clean_q, moved;
  logic [MAXW-1:0] max_d;
  logic [MAXW:0]   seen_q;

  assign moved = (pace_d != pace_rx_i) || (max_d != rx_max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_d   <= 1'b0;
      pace_d  <= 1'b0;
      max_d   <= '0;
      clean_q <= 1'b0;
      seen_q  <= '0;
    end else begin
      win_d  <= win_start_i;
      pace_d <= pace_rx_i;
      max_d  <= rx_max_i;
      if (win_d) begin
        seen_q  <= {{MAXW{1'b0}}, rx_pulse_i};
        clean_q <= pace_rx_i && !moved;
      end else begin
        if (rx_pulse_i && !(&seen_q)) seen_q <= seen_q + 1'b1;
        if (moved) clean_q <= 1'b0;
      end
    end
  end

  AST_RX_PULSE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(pace_rx_i) && rx_pulse_i) |-> $past(|rx_stat_i)); // R2
  AST_TH_PULSE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    th_pulse_i |-> $past(|th_stat_i)); // R4
  AST_MISC_PULSE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misc_pulse_i |-> $past(|misc_stat_i)); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rx_en_i) == '0 && !$past(pace_rx_i)) |-> !rx_pulse_i); // R6
  AST_WINDOW_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clean_q && pace_rx_i && !moved) |-> (seen_q <= {1'b0, rx_max_i})); // R9
endmodule

bind irq_pace_top irq_pace_chk #(.CH(irq_pace_pkg::CH_N), .MW(irq_pace_pkg::MISC_W),
                                 .MAXW(irq_pace_pkg::MAX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .rx_pulse_i(rx_pulse_o), .th_pulse_i(th_pulse_o), .misc_pulse_i(misc_pulse_o),
  .rx_stat_i(rx_stat), .th_stat_i(th_stat), .misc_stat_i(misc_stat),
  .rx_en_i(rx_en), .pace_rx_i(pace_rx), .rx_max_i(rx_max), .win_start_i(win_start)
);

// File: tb/tb_irq_pace_top.sv
`timescale 1ns/100ps
module tb_irq_pace_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  rx_req = '0, tx_req = '0, th_req = '0;
  logic [3:0]  misc_req = '0;
  logic        rx_p, tx_p, th_p, misc_p;

  int     checks = 0, fails = 0, rx_cnt = 0, tx_cnt = 0;
  longint cyc = 0, rx_last = -1;

  // {enable, request} pairs for the receive group, pacing off
  localparam logic [15:0] VEC [0:11] = '{
    16'hFF00, 16'hFF01, 16'hFF01, 16'hFF03, 16'hFF02, 16'hFD03,
    16'h00FF, 16'hF0FF, 16'h0FFF, 16'h0F0F, 16'h8080, 16'h8000};

  always #2.5 clk = ~clk;

  irq_pace_top dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rx_req_i(rx_req), .tx_req_i(tx_req), .th_req_i(th_req), .misc_req_i(misc_req),
    .rx_pulse_o(rx_p), .tx_pulse_o(tx_p), .th_pulse_o(th_p), .misc_pulse_o(misc_p)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rx_p) begin rx_cnt++; rx_last = cyc; end
    if (tx_p) tx_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rx_evt();
    @(negedge clk); rx_req[0] = 1'b1;
    @(negedge clk); rx_req[0] = 1'b0;
  endtask

  task automatic wait_until(input longint t);
    while (cyc < t) @(negedge clk);
    #1;
  endtask

  task automatic find_held(output longint t);
    t = -1;
    for (int k = 0; k < 6 && t < 0; k++) begin
      int c0;
      longint lim;
      c0 = rx_cnt;
      rx_evt();
      repeat (2) @(negedge clk);
      #1;
      if (rx_cnt == c0) begin
        lim = cyc + 1200;
        while (rx_cnt == c0 && cyc < lim) begin @(negedge clk); #1; end
        if (rx_cnt != c0) t = rx_last;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  pen, preq;
    longint tb, t1, t2;
    int c0, c1;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk({rx_p, tx_p, th_p, misc_p} == 4'b0, "R1 pulses", {rx_p, tx_p, th_p, misc_p}, 0);
    for (int a = 0; a <= 10; a++) begin
      rd(4'(a), d);
      chk(d == 0, "R1 register", d, 0);
    end

    // table walk: receive group, pacing off
    pen = '0; preq = '0;
    for (int i = 0; i < 12; i++) begin
      logic [7:0] e, r;
      logic exp_p;
      e = VEC[i][15:8]; r = VEC[i][7:0];
      wr(4'd2, {24'h0, e});
      rx_req = r;
      @(negedge clk); #1;
      exp_p = |((r & e) & ~(preq & pen));
      chk(rx_p == exp_p, "R2/R6 rx pulse", rx_p, exp_p);
      rd(4'd6, d);
      chk(d == {24'h0, r & e}, "R7/R6 rx status", d, r & e);
      pen = e; preq = r;
    end

    // status write has no effect (R7)
    wr(4'd6, 32'hFF);
    rd(4'd6, d);
    chk(d == 0, "R7 status write ignored", d, 0);
    rd(4'd2, d);
    chk(d == 32'h80, "R7 enable untouched", d, 32'h80);
    rx_req = '0;

    // transmit group (R3)
    wr(4'd3, 32'h01);
    @(negedge clk); tx_req = 8'h01;
    @(negedge clk); #1;
    chk(tx_p == 1'b1, "R3 tx pulse", tx_p, 1);
    @(negedge clk); #1;
    chk(tx_p == 1'b0, "R3 tx one cycle", tx_p, 0);
    rd(4'd7, d);
    chk(d == 32'h01, "R3 tx status", d, 1);
    tx_req = '0;

    // threshold group ignores pacing (R4), disabled bit silent (R6)
    wr(4'd0, 32'h0003_0000);
    wr(4'd1, 32'h04);
    @(negedge clk); th_req = 8'h04;
    @(negedge clk); #1;
    chk(th_p == 1'b1, "R4 th pulse under pacing", th_p, 1);
    @(negedge clk); th_req = 8'h00;
    @(negedge clk); th_req = 8'h08;
    @(negedge clk); #1;
    chk(th_p == 1'b0, "R6 th disabled", th_p, 0);
    rd(4'd5, d);
    chk(d == 0, "R6 th status disabled", d, 0);
    th_req = '0;
    wr(4'd0, 32'h0);

    // miscellaneous sources (R5)
    wr(4'd4, 32'h0F);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); misc_req = 4'(1 << b);
      @(negedge clk); #1;
      chk(misc_p == 1'b1, "R5 misc pulse", misc_p, 1);
      rd(4'd8, d);
      chk(d == (32'h1 << b), "R5 misc status", d, 32'h1 << b);
      misc_req = '0;
    end
    wr(4'd4, 32'h0);
    @(negedge clk); misc_req = 4'h4;
    @(negedge clk); #1;
    chk(misc_p == 1'b0, "R6 misc disabled", misc_p, 0);
    misc_req = '0;

    // pacing: budget, merged pulse, window length
    wr(4'd2, 32'h01);
    wr(4'd9, 32'd1);
    wr(4'd0, 32'h0001_0000);
    find_held(tb);
    chk(tb >= 0, "R10 held pulse issued", tb, 0);
    wr(4'd9, 32'd2);
    #1; c0 = rx_cnt;
    wait_until(tb + 10);
    for (int k = 0; k < 4; k++) begin rx_evt(); @(negedge clk); end
    wait_until(tb + 249);
    chk(rx_cnt - c0 == 1, "R9 budget per window", rx_cnt - c0, 1);
    wait_until(tb + 260);
    chk(rx_cnt - c0 == 2, "R10 one merged pulse", rx_cnt - c0, 2);
    chk(rx_last == tb + 250, "R8/R10 window of 250 ticks", rx_last, tb + 250);

    wr(4'd0, 32'h0001_0001);
    wr(4'd9, 32'd1);
    find_held(t1);
    find_held(t2);
    chk(t2 - t1 == 500, "R8 prescale 1 window", t2 - t1, 500);

    // zero budget holds, disable drops held (R9, R11)
    wr(4'd0, 32'h0001_0000);
    wr(4'd9, 32'd0);
    #1; c0 = rx_cnt;
    rx_evt();
    wait_until(cyc + 300);
    chk(rx_cnt == c0, "R9 zero budget holds", rx_cnt - c0, 0);
    wr(4'd0, 32'h0);
    wait_until(cyc + 300);
    chk(rx_cnt == c0, "R11 held dropped", rx_cnt - c0, 0);
    rx_evt(); #1;
    chk(rx_cnt == c0 + 1 && rx_last == cyc, "R11 immediate after disable", rx_cnt - c0, 1);

    // transmit pacing leaves receive alone (R9)
    wr(4'd10, 32'd0);
    wr(4'd0, 32'h0002_0000);
    #1; c0 = rx_cnt; c1 = tx_cnt;
    @(negedge clk); tx_req = 8'h01;
    @(negedge clk); tx_req = 8'h00;
    rx_evt(); #1;
    chk(rx_cnt == c0 + 1, "R9 rx unaffected by tx pacing", rx_cnt - c0, 1);
    wait_until(cyc + 300);
    chk(tx_cnt == c1, "R9 tx zero budget", tx_cnt - c1, 0);
    wr(4'd0, 32'h0);

    finish_run();
  end
endmodule